// File: doc/BRIEF.md
# Software Trace Stimulus Register Bank

This block gives software 32 write-only trace channels inside a 4 KB register window. A 32-bit store to channel n turns into one trace event, carrying the channel number and the stored word, that is handed to a downstream trace queue over a valid/ready push interface. Before any event leaves, three things must agree: the channel's own enable bit, a privilege bit shared by each group of eight channels, and a global enable. A key register protects the configuration registers against stray writes.

Software polls a channel before using it. A read of any channel address returns a ready flag in bit 0. The flag is 1 when the single holding slot toward the push interface is free. A store made while the flag is 0 is discarded. The push interface obeys the usual stream rules. Once valid is raised, the channel number and payload stay frozen until the cycle in which ready is high. The slot becomes free on the next cycle. Back-pressure from the consumer therefore shows up to software as a ready flag of 0 and as the busy bit in the control register.

Top module: `trace_stim_bank`

## Requirements
- R1: After reset, the channel enable, group privilege and control registers read zero, the block is locked (lock status reads 0x3), `pkt_valid` is 0, and a channel read returns 1.
- R2: A permitted store to byte offset 4*n (n = 0..31, bits [1:0] zero) while the slot is free raises `pkt_valid` in the next cycle, with `pkt_port` = n and `pkt_data` = the stored word.
- R3: While `pkt_valid` is 1 and `pkt_ready` is 0, `pkt_valid`, `pkt_port` and `pkt_data` hold their values. After a cycle with both high, `pkt_valid` is 0 in the next cycle.
- R4: A read of any channel offset returns bit 0 = 1 when the slot is free and 0 when it is occupied, with all other bits 0. A store made while the slot is occupied is discarded and leaves the held event unchanged.
- R5: The channel enable register at 0xE00 holds one bit per channel (bit n = channel n). A store to a channel whose bit is 0 produces no event.
- R6: The privilege register at 0xE40 has 4 bits, and bit k covers channels 8k..8k+7. When that bit is 1, an unprivileged store (`bus_priv` = 0) to the group produces no event. A privileged store is unaffected.
- R7: When the global enable (bit 0 of the control register at 0xE80) is 0, no store produces an event.
- R8: Writing 0xC5ACCE55 to 0xFB0 unlocks the block, and writing any other value there locks it. Lock status at 0xFB4 reads bit 0 = 1, bit 1 = locked, bit 2 = 0.
- R9: While the block is locked, writes to 0xE00, 0xE40 and 0xE80 have no effect. Channel stores are not affected by the lock.
- R10: Bit 23 of the control register reads 1 exactly while an event is held in the slot.
- R11: Reads return only the implemented bits: the privilege register returns 4 bits, the control register returns bit 0 and bit 23, and an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_priv | input | 1 | 1 when the current access is privileged |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pkt_valid | output | 1 | A trace event is offered |
| pkt_ready | input | 1 | Consumer accepts the offered event |
| pkt_port | output | 5 | Channel number of the offered event |
| pkt_data | output | 32 | Payload of the offered event |

## Verification
The bench sweeps every channel under several enable masks, and every privilege mask with both privileged and unprivileged stores. A wrong bit-to-channel or bit-to-group mapping therefore drops or leaks events at specific channels. A separate test holds back-pressure on the slot, stores into it again, and checks that the held event keeps its payload and that the ready flag and busy bit report the occupied slot. A slot that is overwritten or released early would show a different payload or a missing busy bit. Key handling is exercised with the correct key and with a key that is off by one. A block that unlocks on a near-miss, or that lets the lock block channel stores, would either change configuration or lose an event.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam logic [11:0] OFS_CHAN_EN   = 12'hE00;
  localparam logic [11:0] OFS_GRP_PRIV  = 12'hE40;
  localparam logic [11:0] OFS_CTRL      = 12'hE80;
  localparam logic [11:0] OFS_KEY       = 12'hFB0;
  localparam logic [11:0] OFS_LOCK_STAT = 12'hFB4;
  localparam logic [31:0] UNLOCK_KEY    = 32'hC5AC_CE55;
  localparam int          CTRL_BUSY_BIT = 23;

  typedef enum logic {SLOT_FREE = 1'b0, SLOT_HELD = 1'b1} slot_state_e;
endpackage

// File: rtl/tsb_cfg_regs.sv
module tsb_cfg_regs
  import tsb_pkg::*;
#(
  parameter int NUM_PORTS  = 32,
  parameter int NUM_GROUPS = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [NUM_PORTS-1:0]  chan_en,
  output logic [NUM_GROUPS-1:0] grp_priv,
  output logic                  global_en,
  output logic                  locked
);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_CHAN_EN);
  localparam logic [ADDR_W-1:0] A_PRIV = ADDR_W'(OFS_GRP_PRIV);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);

  logic key_hit;
  assign key_hit = wr && (addr == A_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_en   <= '0;
      grp_priv  <= '0;
      global_en <= 1'b0;
      locked    <= 1'b1;
    end else if (key_hit) begin
      locked <= (wdata != DATA_W'(UNLOCK_KEY));
    end else if (wr && !locked) begin
      if (addr == A_EN)   chan_en   <= wdata[NUM_PORTS-1:0];
      if (addr == A_PRIV) grp_priv  <= wdata[NUM_GROUPS-1:0];
      if (addr == A_CTRL) global_en <= wdata[0];
    end
  end

  // R9: configuration frozen while locked
  assert_locked_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && locked && addr != A_KEY) |=> ($stable(chan_en) && $stable(grp_priv) && $stable(global_en)));

  // R8: correct key unlocks, any other value locks
  assert_key_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_hit && wdata == DATA_W'(UNLOCK_KEY)) |=> !locked);
  assert_key_relock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_hit && wdata != DATA_W'(UNLOCK_KEY)) |=> locked);
endmodule

// File: rtl/tsb_gate.sv
module tsb_gate #(
  parameter int NUM_PORTS  = 32,
  parameter int GROUP_SIZE = 8,
  parameter int NUM_GROUPS = 4,
  parameter int PORT_W     = 5
) (
  input  logic [PORT_W-1:0]     port_idx,
  input  logic [NUM_PORTS-1:0]  chan_en,
  input  logic [NUM_GROUPS-1:0] grp_priv,
  input  logic                  global_en,
  input  logic                  bus_priv,
  output logic                  allow
);
  logic [NUM_PORTS-1:0] needs_priv;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_grp_map
    assign needs_priv[p] = grp_priv[p / GROUP_SIZE];
  end

  assign allow = global_en && chan_en[port_idx] && (bus_priv || !needs_priv[port_idx]);
endmodule

// File: rtl/tsb_slot.sv
module tsb_slot
  import tsb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PORT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PORT_W-1:0] load_port,
  input  logic [DATA_W-1:0] load_data,
  output logic              free,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [PORT_W-1:0] pkt_port,
  output logic [DATA_W-1:0] pkt_data
);
  slot_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SLOT_FREE;
      pkt_port <= '0;
      pkt_data <= '0;
    end else begin
      case (state)
        SLOT_FREE: if (load) begin
          state    <= SLOT_HELD;
          pkt_port <= load_port;
          pkt_data <= load_data;
        end
        SLOT_HELD: if (pkt_ready) state <= SLOT_FREE;
        default:   state <= SLOT_FREE;
      endcase
    end
  end

  assign pkt_valid = (state == SLOT_HELD);
  assign free      = (state == SLOT_FREE);

  // R3: offered event frozen under back-pressure
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_port) && $stable(pkt_data)));
  // R3: handshake empties the slot
  assert_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready) |=> !pkt_valid);
  // R4: a load into an occupied slot is discarded
  assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && load) |=> ($stable(pkt_data) && $stable(pkt_port)));
  // R2: a load into a free slot is offered next cycle
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (free && load) |=> (pkt_valid && pkt_data == $past(load_data)));
endmodule

// File: rtl/trace_stim_bank.sv
module trace_stim_bank
  import tsb_pkg::*;
#(
  parameter int NUM_PORTS  = 32,
  parameter int GROUP_SIZE = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic                          bus_wr,
  input  logic                          bus_priv,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic                          pkt_valid,
  input  logic                          pkt_ready,
  output logic [$clog2(NUM_PORTS)-1:0]  pkt_port,
  output logic [DATA_W-1:0]             pkt_data
);
  localparam int PORT_W     = $clog2(NUM_PORTS);
  localparam int NUM_GROUPS = (NUM_PORTS + GROUP_SIZE - 1) / GROUP_SIZE;
  localparam int IDX_W      = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_CHAN_EN);
  localparam logic [ADDR_W-1:0] A_PRIV = ADDR_W'(OFS_GRP_PRIV);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_LOCK_STAT);

  logic [NUM_PORTS-1:0]  chan_en;
  logic [NUM_GROUPS-1:0] grp_priv;
  logic                  global_en, locked;
  logic [IDX_W-1:0]      word_idx;
  logic [PORT_W-1:0]     port_idx;
  logic                  chan_hit, chan_wr, allow, slot_free;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign port_idx = word_idx[PORT_W-1:0];
  assign chan_hit = (word_idx < IDX_W'(NUM_PORTS)) && (bus_addr[1:0] == 2'b00);
  assign chan_wr  = bus_wr && chan_hit;

  tsb_cfg_regs #(
    .NUM_PORTS(NUM_PORTS), .NUM_GROUPS(NUM_GROUPS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .chan_en(chan_en), .grp_priv(grp_priv), .global_en(global_en), .locked(locked)
  );

  tsb_gate #(
    .NUM_PORTS(NUM_PORTS), .GROUP_SIZE(GROUP_SIZE), .NUM_GROUPS(NUM_GROUPS), .PORT_W(PORT_W)
  ) u_gate (
    .port_idx(port_idx), .chan_en(chan_en), .grp_priv(grp_priv),
    .global_en(global_en), .bus_priv(bus_priv), .allow(allow)
  );

  tsb_slot #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(chan_wr && allow), .load_port(port_idx),
    .load_data(bus_wdata), .free(slot_free), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_port(pkt_port), .pkt_data(pkt_data)
  );

  always_comb begin
    bus_rdata = '0;
    if (chan_hit) begin
      bus_rdata[0] = slot_free;
    end else if (bus_addr == A_EN) begin
      bus_rdata[NUM_PORTS-1:0] = chan_en;
    end else if (bus_addr == A_PRIV) begin
      bus_rdata[NUM_GROUPS-1:0] = grp_priv;
    end else if (bus_addr == A_CTRL) begin
      bus_rdata[0]             = global_en;
      bus_rdata[CTRL_BUSY_BIT] = !slot_free;
    end else if (bus_addr == A_STAT) begin
      bus_rdata[0] = 1'b1;
      bus_rdata[1] = locked;
    end
  end

  // R7: global enable off blocks every store
  assert_gen_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_wr && !global_en && !pkt_valid) |=> !pkt_valid);
  // R5: disabled channel produces nothing
  assert_chan_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_wr && !chan_en[port_idx] && !pkt_valid) |=> !pkt_valid);
  // R6: unprivileged store into a protected group produces nothing
  assert_priv_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_wr && !bus_priv && grp_priv[port_idx / GROUP_SIZE] && !pkt_valid) |=> !pkt_valid);
endmodule

// File: tb/test_trace_stim_bank.sv
module test_trace_stim_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_priv = 1'b0;
  logic [31:0] bus_rdata;
  logic        pkt_valid;
  logic        pkt_ready = 1'b0;
  logic [4:0]  pkt_port;
  logic [31:0] pkt_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trace_stim_bank i_trace_stim_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_port(pkt_port), .pkt_data(pkt_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic p);
    bus_addr = a; bus_wdata = d; bus_priv = p; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_priv = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic drain();
    pkt_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    pkt_ready = 1'b0;
  endtask

  task automatic try_stim(input int port, input logic [31:0] d, input logic p,
                          input logic exp_push, input string tag);
    wr(12'(port * 4), d, p);
    chk({tag, " valid"}, 32'(pkt_valid), 32'(exp_push));
    if (exp_push) begin
      chk({tag, " port"}, 32'(pkt_port), 32'(port));
      chk({tag, " data"}, pkt_data, d);
      drain();
      chk({tag, " drained"}, 32'(pkt_valid), 32'd0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    logic [31:0] masks [4];
    masks[0] = 32'h0000_0001; masks[1] = 32'h8000_0000;
    masks[2] = 32'hA5C3_0F96; masks[3] = 32'h5A3C_F069;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pkt_valid", 32'(pkt_valid), 32'd0);
    rd(12'hE00, r); chk("R1 chan_en", r, 32'd0);
    rd(12'hE40, r); chk("R1 priv", r, 32'd0);
    rd(12'hE80, r); chk("R1 ctrl", r, 32'd0);
    rd(12'hFB4, r); chk("R1 lock stat", r, 32'h3);
    rd(12'h000, r); chk("R1 chan ready", r, 32'h1);

    // R9 locked: config writes ignored
    wr(12'hE80, 32'h1, 1'b1);
    wr(12'hE00, 32'hFFFF_FFFF, 1'b1);
    wr(12'hE40, 32'hF, 1'b1);
    rd(12'hE80, r); chk("R9 ctrl locked", r, 32'd0);
    rd(12'hE00, r); chk("R9 chan_en locked", r, 32'd0);
    rd(12'hE40, r); chk("R9 priv locked", r, 32'd0);
    try_stim(0, 32'h1111_2222, 1'b1, 1'b0, "R7 disabled at reset");

    // R8 unlock
    wr(12'hFB0, 32'hC5AC_CE55, 1'b0);
    rd(12'hFB4, r); chk("R8 unlocked stat", r, 32'h1);

    wr(12'hE00, 32'hFFFF_FFFF, 1'b0);
    wr(12'hE80, 32'h1, 1'b0);

    // R2 every channel
    for (int n = 0; n < 32; n++)
      try_stim(n, 32'h9E37_79B9 * 32'(n + 1), 1'b0, 1'b1, $sformatf("R2 port %0d", n));

    // R5 enable masks
    for (int m = 0; m < 4; m++) begin
      wr(12'hE00, masks[m], 1'b0);
      for (int n = 0; n < 32; n++)
        try_stim(n, 32'hC0DE_0000 + 32'(m * 64 + n), 1'b0, masks[m][n],
                 $sformatf("R5 mask %0d port %0d", m, n));
    end
    wr(12'hE00, 32'hFFFF_FFFF, 1'b0);

    // R6 privilege groups
    for (int pm = 0; pm < 16; pm++) begin
      wr(12'hE40, 32'(pm), 1'b0);
      for (int g = 0; g < 4; g++) begin
        int port;
        port = g * 8 + ((pm + g) % 8);
        try_stim(port, 32'hBEEF_0000 + 32'(pm * 16 + g), 1'b0, !pm[g],
                 $sformatf("R6 unpriv mask %0d grp %0d", pm, g));
        try_stim(port, 32'hFACE_0000 + 32'(pm * 16 + g), 1'b1, 1'b1,
                 $sformatf("R6 priv mask %0d grp %0d", pm, g));
      end
    end
    wr(12'hE40, 32'h0, 1'b0);

    // R7 global enable off
    wr(12'hE80, 32'h0, 1'b0);
    for (int n = 0; n < 32; n += 7)
      try_stim(n, 32'h7777_0000 + 32'(n), 1'b1, 1'b0, $sformatf("R7 port %0d", n));
    wr(12'hE80, 32'h1, 1'b0);

    // R3 / R4 / R10 back-pressure
    wr(12'h024, 32'hAAAA_5555, 1'b0);
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); @(negedge clk);
      chk("R3 hold valid", 32'(pkt_valid), 32'd1);
      chk("R3 hold port", 32'(pkt_port), 32'd9);
      chk("R3 hold data", pkt_data, 32'hAAAA_5555);
    end
    rd(12'h024, r); chk("R4 ready when held", r, 32'h0);
    rd(12'h07C, r); chk("R4 other port ready when held", r, 32'h0);
    rd(12'hE80, r); chk("R10 busy when held", r, 32'h0080_0001);
    wr(12'h028, 32'h1234_ABCD, 1'b0);
    chk("R4 discard port", 32'(pkt_port), 32'd9);
    chk("R4 discard data", pkt_data, 32'hAAAA_5555);
    drain();
    chk("R3 released", 32'(pkt_valid), 32'd0);
    rd(12'hE80, r); chk("R10 not busy", r, 32'h1);
    rd(12'h028, r); chk("R4 ready after drain", r, 32'h1);

    // R11 readback widths and unmapped
    wr(12'hE40, 32'hFFFF_FFFF, 1'b0);
    rd(12'hE40, r); chk("R11 priv width", r, 32'hF);
    wr(12'hE40, 32'h0, 1'b0);
    wr(12'hE80, 32'hFFFF_FFFF, 1'b0);
    rd(12'hE80, r); chk("R11 ctrl bits", r, 32'h1);
    wr(12'hE00, 32'h1234_5678, 1'b0);
    rd(12'hE00, r); chk("R11 chan_en readback", r, 32'h1234_5678);
    rd(12'h100, r); chk("R11 unmapped", r, 32'h0);

    // R8 near-miss key relocks, R9 stores still pass
    wr(12'hFB0, 32'hC5AC_CE54, 1'b0);
    rd(12'hFB4, r); chk("R8 relocked stat", r, 32'h3);
    wr(12'hE00, 32'h0, 1'b0);
    rd(12'hE00, r); chk("R9 chan_en kept", r, 32'h1234_5678);
    try_stim(3, 32'h0DDB_A11E, 1'b0, 1'b1, "R9 store while locked");
    try_stim(0, 32'h0DDB_A11F, 1'b0, 1'b0, "R5 locked disabled port");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule